// File: doc/BRIEF.md
# Block Cipher Chaining Controller

This block wraps a single-block cipher engine and turns it into an ECB, CBC or CTR mode unit for 128-bit blocks. The host loads key, chaining-value (IV) and input words through a word-wide write port, reads result words through a word-wide read port, and selects mode, direction and automatic or manual launching with level inputs. The controller picks the value handed to the engine, applies the mode's XOR to the engine result, writes the output register and advances the chaining value after every block.

In automatic operation a block launches as soon as all input words are present and the engine is free. A finished result that would overwrite an unread earlier result is held back, and the controller reports a stall until the host drains the output. In manual operation only the start pulse launches a block, whatever has been written, and results overwrite the output register without stalling. A clear pulse wipes all data-bearing registers in one cycle.

Top module: `cmc_top`

## Requirements
- R1: After reset idle_o=1, in_ready_o=1, out_valid_o=0, stall_o=0, iv_o=0 and rd_data_o=0.
- R2: ECB mode (cfg_mode_i=0): the engine receives the input block unchanged, the engine result goes to the output register unchanged, and the IV is not modified by any block.
- R3: CBC encryption (cfg_mode_i=1, cfg_dec_i=0): the engine receives input XOR IV, and after each block the IV is replaced by the produced output block.
- R4: CBC decryption (cfg_mode_i=1, cfg_dec_i=1): the output is the engine result XOR the IV, and the IV is then replaced by the ciphertext just consumed, so the original IV is gone and must be rewritten for a new message.
- R5: CTR mode (cfg_mode_i=2): the engine receives the IV with core_dec_o=0 whatever cfg_dec_i says, the output is the engine result XOR the consumed input block, and the IV then increases by one modulo 2^128.
- R6: In automatic mode a block launches once all four input words (write select 2, word index 0 holds bits 31:0) have been written since the last launch and the controller is idle; in_ready_o is 0 from the fourth write until the block is copied to the engine.
- R7: out_valid_o rises when a result is written to the output register and falls once each of the four output words has been read with rd_en_i.
- R8: In automatic mode, a result arriving while out_valid_o is still 1 raises stall_o with idle_o=0 and leaves the output register untouched; the held result is written after the host finishes reading.
- R9: With cfg_manual_i=1 a start_i pulse launches a block regardless of which input words were written, four writes alone do not launch, and a new result overwrites an unread one without stall.
- R10: A clear_i pulse zeroes IV, input, previous-input and output registers and the input write tracking, drops out_valid_o and returns to idle on the next cycle.
- R11: core_start_o is a single-cycle pulse per launched block, and the key written with write select 0 is presented on core_key_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_mode_i | input | 2 | 0 ECB, 1 CBC, 2 CTR |
| cfg_dec_i | input | 1 | 1 selects decryption |
| cfg_manual_i | input | 1 | 1 selects manual launching |
| wr_en_i | input | 1 | Host word write strobe |
| wr_sel_i | input | 2 | Write target: 0 key, 1 IV, 2 input data |
| wr_idx_i | input | 2 | Word index within the target |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Marks the addressed output word as read |
| rd_idx_i | input | 2 | Output word index |
| rd_data_o | output | 32 | Addressed output word |
| start_i | input | 1 | Manual launch pulse |
| clear_i | input | 1 | Clear pulse |
| iv_o | output | 128 | Current chaining value |
| idle_o | output | 1 | No block in flight or held |
| stall_o | output | 1 | Result held waiting for output read |
| in_ready_o | output | 1 | Input register can take a new block |
| out_valid_o | output | 1 | Output register holds an unread result |
| core_start_o | output | 1 | Engine start pulse |
| core_dec_o | output | 1 | Engine direction |
| core_state_o | output | 128 | Block sent to the engine |
| core_key_o | output | 128 | Key sent to the engine |
| core_done_i | input | 1 | Engine result strobe |
| core_state_i | input | 128 | Engine result |

## Verification
The hardest state to reach is the stall: a second block must complete while the first result is still unread, which needs the host to refill the input register and keep its hands off the read port. The stimulus leaves the first output untouched, writes the next block, waits past the engine latency and then checks the stall flag, the held output and the ordered release once the four words are read. CBC round trips and a CTR counter wrap from all ones exercise the chaining value rewrite paths.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

   typedef enum logic [1:0] {
      MODE_ECB = 2'd0,
      MODE_CBC = 2'd1,
      MODE_CTR = 2'd2
   } cmc_mode_e;

   typedef enum logic [1:0] {
      SEL_KEY = 2'd0,
      SEL_IV  = 2'd1,
      SEL_DIN = 2'd2
   } cmc_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_BUSY  = 2'd1,
      ST_STALL = 2'd2
   } cmc_state_e;

endpackage

// File: rtl/cmc_word_bank.sv
module cmc_word_bank #(
   parameter int WORD_W  = 32,
   parameter int N_WORDS = 4,
   parameter int IDX_W   = 2
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        clr_i,
   input  logic                        we_i,
   input  logic [IDX_W-1:0]            idx_i,
   input  logic [WORD_W-1:0]           wdata_i,
   output logic [N_WORDS*WORD_W-1:0]   data_o
);

   logic [N_WORDS-1:0][WORD_W-1:0] words_q;

   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            words_q[w] <= '0;
         end else if (clr_i) begin
            words_q[w] <= '0;
         end else if (we_i && (idx_i == IDX_W'(w))) begin
            words_q[w] <= wdata_i;
         end
      end
   end

   assign data_o = words_q;

endmodule

// File: rtl/cmc_iv_unit.sv
module cmc_iv_unit
   import cmc_pkg::*;
#(
   parameter int BLK_W   = 128,
   parameter int WORD_W  = 32,
   parameter int N_WORDS = 4,
   parameter int IDX_W   = 2,
   parameter int CTR_W   = 128
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [WORD_W-1:0] wdata_i,
   input  logic              commit_i,
   input  logic [1:0]        mode_i,
   input  logic              dec_i,
   input  logic [BLK_W-1:0]  out_blk_i,
   input  logic [BLK_W-1:0]  prev_blk_i,
   output logic [BLK_W-1:0]  iv_o
);

   logic [BLK_W-1:0] iv_q;
   logic [BLK_W-1:0] iv_inc;
   logic [BLK_W-1:0] iv_nxt;

   if (CTR_W >= BLK_W) begin : g_full_ctr
      assign iv_inc = iv_q + BLK_W'(1);
   end else begin : g_part_ctr
      assign iv_inc = {iv_q[BLK_W-1:CTR_W], iv_q[CTR_W-1:0] + CTR_W'(1)};
   end

   always_comb begin
      iv_nxt = iv_q;
      if (mode_i == MODE_CBC) begin
         iv_nxt = dec_i ? prev_blk_i : out_blk_i;
      end else if (mode_i == MODE_CTR) begin
         iv_nxt = iv_inc;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         iv_q <= '0;
      end else if (clr_i) begin
         iv_q <= '0;
      end else if (commit_i) begin
         iv_q <= iv_nxt;
      end else if (we_i) begin
         for (int w = 0; w < N_WORDS; w++) begin
            if (idx_i == IDX_W'(w)) begin
               iv_q[w*WORD_W +: WORD_W] <= wdata_i;
            end
         end
      end
   end

   assign iv_o = iv_q;

endmodule

// File: rtl/cmc_datapath.sv
module cmc_datapath
   import cmc_pkg::*;
#(
   parameter int BLK_W = 128
) (
   input  logic [1:0]       mode_i,
   input  logic             dec_i,
   input  logic [BLK_W-1:0] din_i,
   input  logic [BLK_W-1:0] iv_i,
   input  logic [BLK_W-1:0] prev_i,
   input  logic [BLK_W-1:0] core_res_i,
   output logic [BLK_W-1:0] core_in_o,
   output logic [BLK_W-1:0] out_blk_o
);

   always_comb begin
      core_in_o = din_i;
      if (mode_i == MODE_CBC && !dec_i) begin
         core_in_o = din_i ^ iv_i;
      end else if (mode_i == MODE_CTR) begin
         core_in_o = iv_i;
      end
   end

   always_comb begin
      out_blk_o = core_res_i;
      if (mode_i == MODE_CBC && dec_i) begin
         out_blk_o = core_res_i ^ iv_i;
      end else if (mode_i == MODE_CTR) begin
         out_blk_o = core_res_i ^ prev_i;
      end
   end

endmodule

// File: rtl/cmc_top.sv
module cmc_top
   import cmc_pkg::*;
#(
   parameter int BLK_W  = 128,
   parameter int WORD_W = 32,
   parameter int KEY_W  = 128,
   parameter int CTR_W  = 128,
   localparam int N_WORDS   = BLK_W / WORD_W,
   localparam int KEY_WORDS = KEY_W / WORD_W,
   localparam int MAX_WORDS = (N_WORDS > KEY_WORDS) ? N_WORDS : KEY_WORDS,
   localparam int IDX_W     = $clog2(MAX_WORDS),
   localparam int RIDX_W    = $clog2(N_WORDS)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [1:0]        cfg_mode_i,
   input  logic              cfg_dec_i,
   input  logic              cfg_manual_i,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_sel_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [WORD_W-1:0] wr_data_i,
   input  logic              rd_en_i,
   input  logic [RIDX_W-1:0] rd_idx_i,
   output logic [WORD_W-1:0] rd_data_o,
   input  logic              start_i,
   input  logic              clear_i,
   output logic [BLK_W-1:0]  iv_o,
   output logic              idle_o,
   output logic              stall_o,
   output logic              in_ready_o,
   output logic              out_valid_o,
   output logic              core_start_o,
   output logic              core_dec_o,
   output logic [BLK_W-1:0]  core_state_o,
   output logic [KEY_W-1:0]  core_key_o,
   input  logic              core_done_i,
   input  logic [BLK_W-1:0]  core_state_i
);

   if ((BLK_W % WORD_W) != 0 || (KEY_W % WORD_W) != 0 || N_WORDS < 2 || KEY_WORDS < 2
       || CTR_W < 1 || CTR_W > BLK_W) begin : g_bad_cfg
      initial $fatal(1, "cmc_top: unsupported width parameters");
   end

   cmc_state_e          st_q;
   logic [N_WORDS-1:0]  din_mask_q;
   logic [N_WORDS-1:0]  rd_mask_q;
   logic [N_WORDS-1:0]  rd_mask_nxt;
   logic [BLK_W-1:0]    prev_q;
   logic [BLK_W-1:0]    dout_q;
   logic [BLK_W-1:0]    res_q;
   logic [BLK_W-1:0]    core_in_q;
   logic                ovalid_q;
   logic                start_q;
   logic                dec_q;

   logic [BLK_W-1:0]    din_data;
   logic [BLK_W-1:0]    iv_data;
   logic [BLK_W-1:0]    dp_core_in;
   logic [BLK_W-1:0]    dp_out;
   logic [BLK_W-1:0]    commit_blk;
   logic                din_we;
   logic                iv_we;
   logic                key_we;
   logic                din_full;
   logic                launch;
   logic                done_ok;
   logic                go_stall;
   logic                commit;
   logic                read_hit;
   logic                read_done;

   assign key_we = wr_en_i && (wr_sel_i == SEL_KEY) && (32'(wr_idx_i) < KEY_WORDS);
   assign iv_we  = wr_en_i && (wr_sel_i == SEL_IV)  && (32'(wr_idx_i) < N_WORDS);
   assign din_we = wr_en_i && (wr_sel_i == SEL_DIN) && (32'(wr_idx_i) < N_WORDS);

   cmc_word_bank #(
      .WORD_W (WORD_W),
      .N_WORDS(KEY_WORDS),
      .IDX_W  (IDX_W)
   ) u_key (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (1'b0),
      .we_i   (key_we),
      .idx_i  (wr_idx_i),
      .wdata_i(wr_data_i),
      .data_o (core_key_o)
   );

   cmc_word_bank #(
      .WORD_W (WORD_W),
      .N_WORDS(N_WORDS),
      .IDX_W  (IDX_W)
   ) u_din (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clear_i),
      .we_i   (din_we),
      .idx_i  (wr_idx_i),
      .wdata_i(wr_data_i),
      .data_o (din_data)
   );

   cmc_datapath #(
      .BLK_W(BLK_W)
   ) u_dp (
      .mode_i    (cfg_mode_i),
      .dec_i     (cfg_dec_i),
      .din_i     (din_data),
      .iv_i      (iv_data),
      .prev_i    (prev_q),
      .core_res_i(core_state_i),
      .core_in_o (dp_core_in),
      .out_blk_o (dp_out)
   );

   cmc_iv_unit #(
      .BLK_W  (BLK_W),
      .WORD_W (WORD_W),
      .N_WORDS(N_WORDS),
      .IDX_W  (IDX_W),
      .CTR_W  (CTR_W)
   ) u_iv (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clear_i),
      .we_i      (iv_we),
      .idx_i     (wr_idx_i),
      .wdata_i   (wr_data_i),
      .commit_i  (commit),
      .mode_i    (cfg_mode_i),
      .dec_i     (cfg_dec_i),
      .out_blk_i (commit_blk),
      .prev_blk_i(prev_q),
      .iv_o      (iv_data)
   );

   // Launch and completion control
   assign din_full   = &din_mask_q;
   assign launch     = (st_q == ST_IDLE) && !clear_i && (cfg_manual_i ? start_i : din_full);
   assign done_ok    = (st_q == ST_BUSY) && core_done_i && !clear_i;
   assign go_stall   = done_ok && !cfg_manual_i && ovalid_q;
   assign commit     = (done_ok && !go_stall) || ((st_q == ST_STALL) && !ovalid_q && !clear_i);
   assign commit_blk = (st_q == ST_STALL) ? res_q : dp_out;

   assign read_hit    = rd_en_i && ovalid_q;
   assign rd_mask_nxt = rd_mask_q | (N_WORDS'(1) << rd_idx_i);
   assign read_done   = read_hit && (&rd_mask_nxt);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q <= ST_IDLE;
      end else if (clear_i) begin
         st_q <= ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE:  if (launch) st_q <= ST_BUSY;
            ST_BUSY:  if (done_ok) st_q <= go_stall ? ST_STALL : ST_IDLE;
            ST_STALL: if (commit) st_q <= ST_IDLE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         din_mask_q <= '0;
      end else if (clear_i) begin
         din_mask_q <= '0;
      end else begin
         din_mask_q <= (launch ? '0 : din_mask_q)
                       | (din_we ? (N_WORDS'(1) << wr_idx_i) : '0);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         start_q   <= 1'b0;
         dec_q     <= 1'b0;
         core_in_q <= '0;
         prev_q    <= '0;
      end else if (clear_i) begin
         start_q   <= 1'b0;
         dec_q     <= 1'b0;
         core_in_q <= '0;
         prev_q    <= '0;
      end else begin
         start_q <= launch;
         if (launch) begin
            dec_q     <= cfg_dec_i && (cfg_mode_i != MODE_CTR);
            core_in_q <= dp_core_in;
            prev_q    <= din_data;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         res_q <= '0;
      end else if (clear_i) begin
         res_q <= '0;
      end else if (go_stall) begin
         res_q <= dp_out;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         dout_q    <= '0;
         ovalid_q  <= 1'b0;
         rd_mask_q <= '0;
      end else if (clear_i) begin
         dout_q    <= '0;
         ovalid_q  <= 1'b0;
         rd_mask_q <= '0;
      end else if (commit) begin
         dout_q    <= commit_blk;
         ovalid_q  <= 1'b1;
         rd_mask_q <= '0;
      end else if (read_done) begin
         ovalid_q  <= 1'b0;
         rd_mask_q <= '0;
      end else if (read_hit) begin
         rd_mask_q <= rd_mask_nxt;
      end
   end

   assign rd_data_o    = dout_q[rd_idx_i*WORD_W +: WORD_W];
   assign iv_o         = iv_data;
   assign idle_o       = (st_q == ST_IDLE);
   assign stall_o      = (st_q == ST_STALL);
   assign in_ready_o   = !din_full;
   assign out_valid_o  = ovalid_q;
   assign core_start_o = start_q;
   assign core_dec_o   = dec_q;
   assign core_state_o = core_in_q;

endmodule

// File: rtl/cmc_chk.sv
module cmc_chk #(
   parameter int BLK_W  = 128,
   parameter int WORD_W = 32
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [1:0]        cfg_mode_i,
   input logic              cfg_manual_i,
   input logic              wr_en_i,
   input logic [1:0]        wr_sel_i,
   input logic              rd_en_i,
   input logic              clear_i,
   input logic [WORD_W-1:0] rd_data_o,
   input logic [BLK_W-1:0]  iv_o,
   input logic              idle_o,
   input logic              stall_o,
   input logic              in_ready_o,
   input logic              out_valid_o,
   input logic              core_start_o
);

   assert_start_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      core_start_o |=> !core_start_o);

   assert_launch_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      core_start_o |-> !idle_o);

   assert_stall_not_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_o |-> !idle_o);

   assert_stall_auto_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(stall_o) |-> !$past(cfg_manual_i));

   assert_clear_state_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (iv_o == '0) && !out_valid_o && idle_o && in_ready_o && (rd_data_o == '0));

   assert_ecb_iv_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_mode_i == 2'd0) && !clear_i && !(wr_en_i && wr_sel_i == 2'd1) |=> $stable(iv_o));

   assert_ovalid_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o && !rd_en_i && !clear_i |=> out_valid_o);

endmodule

bind cmc_top cmc_chk #(
   .BLK_W (BLK_W),
   .WORD_W(WORD_W)
) u_cmc_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .cfg_mode_i  (cfg_mode_i),
   .cfg_manual_i(cfg_manual_i),
   .wr_en_i     (wr_en_i),
   .wr_sel_i    (wr_sel_i),
   .rd_en_i     (rd_en_i),
   .clear_i     (clear_i),
   .rd_data_o   (rd_data_o),
   .iv_o        (iv_o),
   .idle_o      (idle_o),
   .stall_o     (stall_o),
   .in_ready_o  (in_ready_o),
   .out_valid_o (out_valid_o),
   .core_start_o(core_start_o)
);

// File: tb/tb_cmc_top.sv
module tb_cmc_top;

   localparam int LAT = 6;
   localparam logic [127:0] KEY = 128'h2b7e1516_28aed2a6_abf71588_09cf4f3c;
   localparam logic [127:0] IV0 = 128'h00010203_04050607_08090a0b_0c0d0e0f;

   // {mode, dec, block}
   localparam logic [130:0] TBL [8] = '{
      {2'd0, 1'b0, 128'h6bc1bee2_2e409f96_e93d7e11_7393172a},
      {2'd0, 1'b1, 128'hae2d8a57_1e03ac9c_9eb76fac_45af8e51},
      {2'd1, 1'b0, 128'h30c81c46_a35ce411_e5fbc119_1a0a52ef},
      {2'd1, 1'b0, 128'hf69f2445_df4f9b17_ad2b417b_e66c3710},
      {2'd1, 1'b1, 128'h01234567_89abcdef_fedcba98_76543210},
      {2'd2, 1'b0, 128'hdeadbeef_cafef00d_01020304_a5a5a5a5},
      {2'd2, 1'b1, 128'h11111111_22222222_33333333_44444444},
      {2'd0, 1'b0, 128'h00000000_00000000_00000000_00000001}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [1:0]   cfg_mode = 2'd0;
   logic         cfg_dec = 1'b0;
   logic         cfg_manual = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_sel = 2'd0;
   logic [1:0]   wr_idx = 2'd0;
   logic [31:0]  wr_data = '0;
   logic         rd_en = 1'b0;
   logic [1:0]   rd_idx = 2'd0;
   logic [31:0]  rd_data;
   logic         start = 1'b0;
   logic         clear = 1'b0;
   logic [127:0] iv;
   logic         idle, stall, in_ready, out_valid;
   logic         core_start, core_dec;
   logic [127:0] core_state, core_key;
   logic         core_done;
   logic [127:0] core_res;

   cmc_top dut (
      .clk_i(clk), .rst_ni(rst_n),
      .cfg_mode_i(cfg_mode), .cfg_dec_i(cfg_dec), .cfg_manual_i(cfg_manual),
      .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
      .rd_en_i(rd_en), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
      .start_i(start), .clear_i(clear), .iv_o(iv),
      .idle_o(idle), .stall_o(stall), .in_ready_o(in_ready), .out_valid_o(out_valid),
      .core_start_o(core_start), .core_dec_o(core_dec), .core_state_o(core_state),
      .core_key_o(core_key), .core_done_i(core_done), .core_state_i(core_res)
   );

   // Reversible engine model: rotate by one byte and mix in the key.
   function automatic logic [127:0] eng_enc(input logic [127:0] x, input logic [127:0] k);
      return {x[119:0], x[127:120]} ^ k;
   endfunction
   function automatic logic [127:0] eng_dec(input logic [127:0] y, input logic [127:0] k);
      logic [127:0] t;
      t = y ^ k;
      return {t[7:0], t[127:8]};
   endfunction

   logic [127:0] eng_in;
   logic         eng_dir;
   logic         eng_busy;
   int           eng_cnt;
   int           dbl_start;
   logic         start_prev;

   always @(posedge clk) begin
      core_done <= 1'b0;
      if (!rst_n) begin
         eng_busy <= 1'b0;
         eng_cnt  <= 0;
         core_res <= '0;
      end else if (core_start) begin
         eng_busy <= 1'b1;
         eng_cnt  <= LAT;
         eng_in   <= core_state;
         eng_dir  <= core_dec;
      end else if (eng_busy) begin
         if (eng_cnt == 1) begin
            core_done <= 1'b1;
            core_res  <= eng_dir ? eng_dec(eng_in, core_key) : eng_enc(eng_in, core_key);
            eng_busy  <= 1'b0;
         end
         eng_cnt <= eng_cnt - 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && core_start && start_prev) dbl_start++;
      start_prev = core_start;
   end

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;
   logic [127:0] ref_iv;

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_word(input logic [1:0] sel, input logic [1:0] idx, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr_block(input logic [1:0] sel, input logic [127:0] b);
      for (int w = 0; w < 4; w++) wr_word(sel, 2'(w), b[w*32 +: 32]);
   endtask

   task automatic rd_block(output logic [127:0] b);
      for (int w = 0; w < 4; w++) begin
         @(negedge clk);
         rd_en = 1'b1; rd_idx = 2'(w);
         #0.1 b[w*32 +: 32] = rd_data;
      end
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wait_ovalid();
      int n = 0;
      while (!out_valid && n < 200) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic pulse(input bit is_clear);
      @(negedge clk);
      if (is_clear) clear = 1'b1; else start = 1'b1;
      @(negedge clk);
      clear = 1'b0; start = 1'b0;
   endtask

   task automatic ref_block(input logic [1:0] m, input logic d, input logic [127:0] x,
                            output logic [127:0] y);
      case (m)
         2'd1: if (!d) begin y = eng_enc(x ^ ref_iv, KEY); ref_iv = y; end
               else begin y = eng_dec(x, KEY) ^ ref_iv; ref_iv = x; end
         2'd2: begin y = eng_enc(ref_iv, KEY) ^ x; ref_iv = ref_iv + 128'd1; end
         default: y = d ? eng_dec(x, KEY) : eng_enc(x, KEY);
      endcase
   endtask

   function automatic string tag_of(input logic [1:0] m, input logic d);
      if (m == 2'd1) return d ? "R4" : "R3";
      if (m == 2'd2) return "R5";
      return "R2";
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [127:0] got, exp, exp_a, exp_b, p1, p2, c1, c2;
      dbl_start = 0;
      start_prev = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values
      check("R1 status", {124'd0, idle, in_ready, out_valid, stall}, {124'd0, 4'b1100});
      check("R1 iv", iv, '0);
      check("R1 rd_data", {96'd0, rd_data}, '0);

      wr_block(2'd0, KEY);
      check("R11 key", core_key, KEY);
      wr_block(2'd1, IV0);
      ref_iv = IV0;

      // Vector table, automatic mode
      foreach (TBL[i]) begin
         cfg_mode = TBL[i][130:129];
         cfg_dec  = TBL[i][128];
         ref_block(cfg_mode, cfg_dec, TBL[i][127:0], exp);
         wr_block(2'd2, TBL[i][127:0]);
         check("R6 in_ready low after fourth write", {127'd0, in_ready}, '0);
         wait_ovalid();
         check("R7 out_valid set", {127'd0, out_valid}, 128'd1);
         rd_block(got);
         check({tag_of(cfg_mode, cfg_dec), " output"}, got, exp);
         check({tag_of(cfg_mode, cfg_dec), " iv update"}, iv, ref_iv);
         check("R7 out_valid cleared after reads", {127'd0, out_valid}, '0);
         check("R6 in_ready restored", {127'd0, in_ready}, 128'd1);
      end

      // R4: CBC round trip, original IV lost
      p1 = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
      p2 = 128'h55aa55aa_12345678_9abcdef0_0badc0de;
      cfg_mode = 2'd1; cfg_dec = 1'b0;
      wr_block(2'd1, IV0); ref_iv = IV0;
      wr_block(2'd2, p1); wait_ovalid(); rd_block(c1);
      wr_block(2'd2, p2); wait_ovalid(); rd_block(c2);
      check("R3 iv holds last ciphertext", iv, c2);
      cfg_dec = 1'b1;
      wr_block(2'd1, IV0);
      wr_block(2'd2, c1); wait_ovalid(); rd_block(got);
      check("R4 decrypt first block", got, p1);
      check("R4 iv holds consumed ciphertext", iv, c1);
      wr_block(2'd2, c2); wait_ovalid(); rd_block(got);
      check("R4 decrypt second block", got, p2);

      // R5: counter wrap
      cfg_mode = 2'd2; cfg_dec = 1'b1;
      wr_block(2'd1, '1);
      wr_block(2'd2, 128'h0);
      wait_ovalid(); rd_block(got);
      check("R5 ctr output at all ones", got, eng_enc('1, KEY));
      check("R5 ctr wraps to zero", iv, '0);

      // R8: stall when earlier output unread
      cfg_mode = 2'd0; cfg_dec = 1'b0;
      exp_a = eng_enc(TBL[0][127:0], KEY);
      exp_b = eng_enc(TBL[3][127:0], KEY);
      wr_block(2'd2, TBL[0][127:0]);
      wait_ovalid();
      wr_block(2'd2, TBL[3][127:0]);
      check("R6 in_ready low before copy", {127'd0, in_ready}, '0);
      repeat (LAT + 8) @(negedge clk);
      check("R8 stall raised", {127'd0, stall}, 128'd1);
      check("R8 not idle while stalled", {127'd0, idle}, '0);
      check("R6 in_ready back after copy", {127'd0, in_ready}, 128'd1);
      rd_block(got);
      check("R8 first result kept", got, exp_a);
      wait_ovalid();
      check("R8 stall released", {127'd0, stall}, '0);
      rd_block(got);
      check("R8 held result delivered", got, exp_b);

      // R10: clear
      wr_block(2'd1, IV0);
      wr_word(2'd2, 2'd0, 32'h1);
      wr_word(2'd2, 2'd1, 32'h2);
      wr_word(2'd2, 2'd2, 32'h3);
      pulse(1'b1);
      check("R10 iv zeroed", iv, '0);
      check("R10 status after clear", {124'd0, idle, in_ready, out_valid, stall}, {124'd0, 4'b1100});
      wr_word(2'd2, 2'd3, 32'h4);
      repeat (LAT + 8) @(negedge clk);
      check("R10 write tracking cleared, no launch", {127'd0, out_valid}, '0);

      // R9: manual launch on whatever is present (input words cleared except word 3)
      cfg_manual = 1'b1;
      pulse(1'b0);
      wait_ovalid();
      rd_block(got);
      check("R9 manual start with partial input, R10 input zeroed", got,
            eng_enc({32'h4, 96'd0}, KEY));
      wr_block(2'd2, p1);
      repeat (LAT + 8) @(negedge clk);
      check("R9 four writes do not launch", {126'd0, out_valid, idle}, 128'd1);
      pulse(1'b0);
      wait_ovalid();
      wr_word(2'd2, 2'd0, 32'hffff0000);
      pulse(1'b0);
      repeat (LAT + 8) @(negedge clk);
      check("R9 no stall in manual", {127'd0, stall}, '0);
      rd_block(got);
      check("R9 unread result overwritten", got,
            eng_enc({p1[127:32], 32'hffff0000}, KEY));
      check("R11 start pulses single cycle", 128'(dbl_start), '0);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule